// File: doc/BRIEF.md
# Alternating Dual-Pump Level Controller

This block runs two drainage pumps from a pair of water-level probes. The upper probe sets the level at which pumping begins, and the lower probe sets the level at which it ends. Between the two levels the controller keeps doing what it was already doing. A level that is falling keeps the running pump on. A level that is rising leaves both pumps off until water reaches the upper probe.

Each new pumping cycle uses the pump that sat idle during the previous one, which spreads wear over both pumps. If the upper probe reads wet while the lower probe reads dry, the lower probe must be broken. The controller then freezes its state and raises a fault flag for as long as that reading lasts.

All outputs come from registers and change one clock after the inputs are sampled. The state encoding is fixed as follows:
- bit 0 tells whether a pump is running.
- bit 1 selects pump 2 when set.
- Idle states: 00 means idle with pump 1 next, and 10 means idle with pump 2 next.
- Running states: 01 means pump 1 is running, and 11 means pump 2 is running.

Top module: `pump_alternator`

## Requirements
- R1: After reset both pump enables and fault are 0, and the first pumping cycle uses pump 1.
- R2: When idle and both probes read 1 at a clock edge, the enable of the pump chosen to go next is 1 from that edge on.
- R3: Pumping cycles alternate. After a cycle on pump 1 the next start uses pump 2, and after a cycle on pump 2 the next start uses pump 1.
- R4: When a pump is running and both probes read 0 at a clock edge, both enables are 0 from that edge on.
- R5: Upper probe 0 with lower probe 1 changes nothing. A running pump stays on, and an idle controller stays idle.
- R6: Both probes at 1 while a pump runs keep that same pump running, with no switch to the other pump.
- R7: Upper probe 1 with lower probe 0 at a clock edge sets fault to 1 from that edge on. The enables and the choice of the next pump are held unchanged.
- R8: Any other probe combination at a clock edge clears fault from that edge on.
- R9: The two pump enables are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_wet | input | 1 | Upper probe, 1 when water is present at the start level |
| lo_wet | input | 1 | Lower probe, 1 when water is present at the stop level |
| pump1_on | output | 1 | Enable for pump 1 |
| pump2_on | output | 1 | Enable for pump 2 |
| fault | output | 1 | Probe fault, 1 while the impossible reading persists |

## Verification
The block has no parameters, so the bench builds it exactly as it would be used. The bench drives a simulated water level that random-walks between three bands, and it injects the broken-probe reading every so often. This reaches every state transition many times, including a fault in the middle of a pumping cycle and a fault while idle. Directed steps before the random walk pin down the first start on pump 1, both directions through the hysteresis band, and the alternation being kept across a fault.

// File: rtl/pump_alt_pkg.sv
package pump_alt_pkg;

  // bit0: a pump is running, bit1: pump 2 is the selected pump
  typedef enum logic [1:0] {
    OFF_NEXT1 = 2'b00,
    P1_RUN    = 2'b01,
    OFF_NEXT2 = 2'b10,
    P2_RUN    = 2'b11
  } pumpState_t;

  typedef struct packed {
    logic start;  // begin a cycle on the selected pump
    logic stop;   // end the cycle, hand over to the other pump
    logic hold;   // impossible probe reading: freeze and flag
  } ctrlStrobe_t;

endpackage

// File: rtl/pump_alt_ctrl.sv
module pump_alt_ctrl
  import pump_alt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hiWet,
  input  logic        loWet,
  input  pumpState_t  curState,
  output ctrlStrobe_t strobe
);

  logic running;
  assign running = curState[0];

  always_comb begin
    strobe       = '0;
    strobe.hold  = hiWet & ~loWet;
    strobe.start = hiWet & loWet & ~running;
    strobe.stop  = ~hiWet & ~loWet & running;
  end

  // R7: a frozen cycle never also starts or stops a pump
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.start, strobe.stop, strobe.hold}));

endmodule

// File: rtl/pump_alt_dp.sv
module pump_alt_dp
  import pump_alt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t strobe,
  output pumpState_t  curState,
  output logic        pump1On,
  output logic        pump2On,
  output logic        faultFlag
);

  pumpState_t nextState;

  always_comb begin
    nextState = curState;
    if (strobe.hold)
      nextState = curState;
    else if (strobe.start)
      nextState = pumpState_t'({curState[1], 1'b1});
    else if (strobe.stop)
      nextState = pumpState_t'({~curState[1], 1'b0});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curState  <= OFF_NEXT1;
      faultFlag <= 1'b0;
    end else begin
      curState  <= nextState;
      faultFlag <= strobe.hold;
    end
  end

  assign pump1On = (curState == P1_RUN);
  assign pump2On = (curState == P2_RUN);

  p_one_pump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump1On && pump2On));

  p_hold_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.hold |=> $stable(curState));

  p_handover_p1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == P1_RUN && strobe.stop) |=> curState == OFF_NEXT2);

  p_handover_p2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == P2_RUN && strobe.stop) |=> curState == OFF_NEXT1);

  p_start_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == OFF_NEXT1 && strobe.start) |=> pump1On);

endmodule

// File: rtl/pump_alternator.sv
module pump_alternator
  import pump_alt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hi_wet,
  input  logic lo_wet,
  output logic pump1_on,
  output logic pump2_on,
  output logic fault
);

  pumpState_t  curState;
  ctrlStrobe_t strobe;

  pump_alt_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hiWet    (hi_wet),
    .loWet    (lo_wet),
    .curState (curState),
    .strobe   (strobe)
  );

  pump_alt_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .curState  (curState),
    .pump1On   (pump1_on),
    .pump2On   (pump2_on),
    .faultFlag (fault)
  );

  p_fault_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wet && !lo_wet) |=> fault);

  p_fault_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_wet && !lo_wet) |=> !fault);

  p_dry_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wet && !lo_wet) |=> !(pump1_on || pump2_on));

  p_band_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wet && lo_wet) |=> ($stable(pump1_on) && $stable(pump2_on)));

endmodule

// File: tb/sim_pump_alternator.sv
module sim_pump_alternator;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hiWet = 1'b0;
  logic loWet = 1'b0;
  logic pump1On, pump2On, faultOut;

  int nChecks = 0;
  int nFails  = 0;

  // model: running flag and selected pump (0 = pump 1, 1 = pump 2)
  logic mRun = 1'b0;
  logic mSel = 1'b0;
  logic mFault = 1'b0;

  always #2.5 clk = ~clk;

  pump_alternator u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_wet   (hiWet),
    .lo_wet   (loWet),
    .pump1_on (pump1On),
    .pump2_on (pump2On),
    .fault    (faultOut)
  );

  function automatic logic [1:0] modelNext(logic run, logic sel, logic hi, logic lo);
    if (hi && !lo)       return {sel, run};
    if (hi && lo && !run) return {sel, 1'b1};
    if (!hi && !lo && run) return {~sel, 1'b0};
    return {sel, run};
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {p1,p2,fault} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(logic hi, logic lo, string tag);
    logic [1:0] nx;
    hiWet = hi;
    loWet = lo;
    nx = modelNext(mRun, mSel, hi, lo);
    @(negedge clk);
    mSel = nx[1];
    mRun = nx[0];
    mFault = hi & ~lo;
    check(tag, {pump1On, pump2On, faultOut}, {mRun & ~mSel, mRun & mSel, mFault});
    nChecks++;
    if (pump1On && pump2On) begin
      nFails++;
      $display("FAIL R9: both enables actual=11 expected not 11");
    end
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    int level;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1 reset", {pump1On, pump2On, faultOut}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b1, "R5 rising idle");
    step(1'b1, 1'b1, "R1 R2 first start pump1");
    step(1'b1, 1'b1, "R6 stay pump1");
    step(1'b0, 1'b1, "R5 falling keep");
    step(1'b0, 1'b0, "R4 stop");
    step(1'b0, 1'b1, "R5 rising stays off");
    step(1'b1, 1'b1, "R3 start pump2");
    step(1'b1, 1'b0, "R7 fault while running");
    step(1'b1, 1'b0, "R7 fault persists");
    step(1'b0, 1'b0, "R8 fault clears, R4 stop");
    step(1'b1, 1'b0, "R7 fault while idle");
    step(1'b1, 1'b1, "R3 pump1 after fault");
    step(1'b0, 1'b0, "R4 stop pump1");
    step(1'b1, 1'b1, "R3 pump2 again");
    // async reset mid-cycle
    rst_n = 1'b0;
    #1;
    mRun = 1'b0; mSel = 1'b0; mFault = 1'b0;
    check("R1 reset mid-cycle", {pump1On, pump2On, faultOut}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    hiWet = 1'b0; loWet = 1'b0;
    @(negedge clk);
    // random walk of the water level: 0 dry, 1 band, 2 above
    level = 0;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) begin
        step(1'b1, 1'b0, "R7 random fault");
      end else begin
        if (r < 5 && level < 2) level++;
        else if (r >= 5 && level > 0) level--;
        step(level == 2, level >= 1, "R3 random walk");
      end
    end
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule